// File: doc/BRIEF.md
# Dual-Device Parallel Flash Command Sequencer

This block sits on the host side of a 32-bit memory bus built from two 16-bit NOR flash devices placed side by side. A client issues one high-level request at a time: read the identification words, erase a block, lock a block, unlock a block, program a line through the device write buffer, or clear and check status. The block turns that request into the right series of bus write and read cycles. Every command byte is copied into all four byte lanes, so both devices see the same command at the same time.

Operations that take time inside the devices end with a status poll. The poll repeats until both 16-bit halves report ready, or until a cycle-count limit runs out. Every request, whether it succeeds, fails or times out, ends with a read-array command to the base address. It then reports a result word, an error flag and a timeout flag.

The bus side is a plain synchronous port. It has an address, write data, read data, write and read strobes, and an acknowledge. A strobe is held until it is acknowledged.

Top module: `flash_cmd_seq`

## Requirements
- R1: A bus cycle raises exactly one of `bus_we` and `bus_re`. It holds the strobe, address and write data unchanged until `bus_ack`. Read identification writes 0x90909090 at the base, reads the base into `id_vendor`, writes 0x90909090 at base+4, reads base+4 into `id_device`, then returns 0.
- R2: A status word counts as ready only when bit 7 and bit 23 are both set. A word with only one of these bits set is treated as not ready.
- R3: Block erase does the following, all at the base address: write 0x50505050, write 0x70707070, then read status. If that status is not ready, the erase stops and returns the raw status. Otherwise it writes 0x20202020, then 0xD0D0D0D0, then polls.
- R4: Unlock writes 0x60606060 then 0xD0D0D0D0. Lock writes 0x60606060 then 0x01010101. Both then poll.
- R5: Line program writes 0xE8E8E8E8 at the base and reads the base back. If that word is not ready, the request stops and returns the raw word.
- R6: After a ready read-back, line program writes the count word at the base. N is `req_len`/4, and the count word holds N-1 in every byte lane. It then writes N words from `line_data` at base+4*i for i = 0 to N-1, pulsing `line_pop` once per accepted word. It then writes 0xD0D0D0D0 at the base and polls.
- R7: Every request ends with a write of 0xFFFFFFFF at the base address. This includes the abort paths and the timeout path.
- R8: A poll is a write of 0x70707070 followed by a read, both at the base, repeated while not ready. On ready, the result is 0 when the status equals exactly 0x00800080, and the raw status otherwise. `res_error` is set when any of bits 5, 4, 3, 1, 21, 20, 19 or 17 is set in the returned status.
- R9: A poll cycle counter starts at poll entry. If a not-ready status is read once the counter has reached `poll_limit`, the poll stops. The result is then 0xFFFFFFFF, with both `res_timeout` and `res_error` set.
- R10: `busy` rises in the cycle after a request is accepted and falls after the final read-array write is acknowledged. `done` pulses for one cycle as `busy` falls. A `req_valid` seen while busy is ignored.
- R11: Status check writes 0x50505050, then 0x70707070, reads the status, and writes read-array. It returns 0 with no error when ready. Otherwise it returns the raw status and flags error from the error bits.
- R12: Out of reset, `busy`, `done`, `bus_we`, `bus_re` and `line_pop` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_op | input | 3 | Operation: 0 identify, 1 erase, 2 lock, 3 unlock, 4 line program, 5 status check |
| req_addr | input | AW | Base (block or line) byte address, 4-byte aligned |
| req_len | input | LW | Line program length in bytes |
| poll_limit | input | TW | Poll timeout in clock cycles |
| line_data | input | 32 | Next data word for line program |
| line_pop | output | 1 | Current `line_data` word was written |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| res_status | output | 32 | Result word |
| res_timeout | output | 1 | Poll timed out |
| res_error | output | 1 | Error flag |
| id_vendor | output | 32 | Word read at the base by identify |
| id_device | output | 32 | Word read at base+4 by identify |
| bus_addr | output | AW | Bus byte address |
| bus_wdata | output | 32 | Bus write data |
| bus_we | output | 1 | Bus write strobe |
| bus_re | output | 1 | Bus read strobe |
| bus_rdata | input | 32 | Bus read data |
| bus_ack | input | 1 | Bus cycle acknowledge |

## Verification
A wrong state in the sequencer shows up as a wrong bus cycle: a misplaced command word, a missing or extra poll pair, or a data word at a shifted address. Each of these appears in the very next transaction, so the bench compares the full ordered cycle trace of every request against one it builds on its own. A wrong result, a wrong flag or a lost read-array only shows at the `done` pulse, a few cycles after the last acknowledge. A stuck poll counter only shows as a missed timeout, one limit's worth of cycles later.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [2:0] {
    OP_IDENT   = 3'd0,
    OP_ERASE   = 3'd1,
    OP_LOCK    = 3'd2,
    OP_UNLOCK  = 3'd3,
    OP_PROGRAM = 3'd4,
    OP_STATUS  = 3'd5
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_CLR, S_CHKQ, S_CHKR, S_SETUP, S_IDV, S_ID2, S_IDD,
    S_CONF, S_PRDBK, S_COUNT, S_DATA, S_COMMIT, S_POLLQ, S_POLLR, S_ARRAY
  } seq_state_e;

  localparam logic [7:0] C_ARRAY   = 8'hFF;
  localparam logic [7:0] C_IDENT   = 8'h90;
  localparam logic [7:0] C_STAT    = 8'h70;
  localparam logic [7:0] C_CLEAR   = 8'h50;
  localparam logic [7:0] C_BUFWR   = 8'hE8;
  localparam logic [7:0] C_ERASE   = 8'h20;
  localparam logic [7:0] C_LOCKSET = 8'h60;
  localparam logic [7:0] C_CONFIRM = 8'hD0;
  localparam logic [7:0] C_LOCKCNF = 8'h01;

  localparam logic [31:0] BOTH_READY = 32'h0080_0080;
  localparam logic [31:0] ERR_BITS   = 32'h003A_003A;
  localparam int unsigned STRIDE     = 4;

  // copy one command byte into every lane of the 32-bit bus
  function automatic logic [31:0] lanes(input logic [7:0] b);
    return {4{b}};
  endfunction

  function automatic logic both_ready(input logic [31:0] s);
    return (s & BOTH_READY) == BOTH_READY;
  endfunction

  function automatic logic any_error(input logic [31:0] s);
    return (s & ERR_BITS) != 32'h0;
  endfunction

  // per-device word count minus one, in every lane
  function automatic logic [31:0] count_word(input logic [7:0] n);
    return lanes(n) - 32'h0101_0101;
  endfunction

endpackage

// File: rtl/flash_poll_timer.sv
module flash_poll_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          run,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  localparam logic [TW-1:0] CNT_MAX = '1;

  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt <= '0;
    else if (clear)                 cnt <= '0;
    else if (run && cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt >= limit);

  AST_TIMER_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && !clear) |=> (cnt == CNT_MAX)); // R9
  AST_TIMER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt == '0)); // R9
endmodule

// File: rtl/flash_word_index.sv
module flash_word_index #(
  parameter int NW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step,
  input  logic [NW-1:0] total,
  output logic [NW-1:0] idx,
  output logic          last
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     idx <= '0;
    else if (clear) idx <= '0;
    else if (step)  idx <= idx + 1'b1;
  end

  assign last = (idx == total - NW'(1));

  AST_INDEX_STEPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear) |=> (idx == $past(idx) + NW'(1))); // R6
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int AW = 24,
  parameter int LW = 8,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [LW-1:0] req_len,
  input  logic [TW-1:0] poll_limit,
  input  logic [31:0]   line_data,
  output logic          line_pop,
  output logic          busy,
  output logic          done,
  output logic [31:0]   res_status,
  output logic          res_timeout,
  output logic          res_error,
  output logic [31:0]   id_vendor,
  output logic [31:0]   id_device,
  output logic [AW-1:0] bus_addr,
  output logic [31:0]   bus_wdata,
  output logic          bus_we,
  output logic          bus_re,
  input  logic [31:0]   bus_rdata,
  input  logic          bus_ack
);
  localparam int NW = LW - 2;

  seq_state_e    st;
  op_e           op_q;
  logic [AW-1:0] base_q;
  logic [NW-1:0] nw_q;
  logic [TW-1:0] lim_q;

  // named internal events
  logic          accept, xfer_done, in_poll, poll_expired, word_last, rd_ready;
  logic [NW-1:0] word_idx;
  logic [7:0]    setup_cmd;

  assign accept    = req_valid && (st == S_IDLE);
  assign xfer_done = bus_ack && (bus_we || bus_re);
  assign in_poll   = (st == S_POLLQ) || (st == S_POLLR);
  assign rd_ready  = both_ready(bus_rdata);
  assign line_pop  = xfer_done && (st == S_DATA);
  assign busy      = (st != S_IDLE);

  flash_poll_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(!in_poll), .run(in_poll),
    .limit(lim_q), .expired(poll_expired)
  );

  flash_word_index #(.NW(NW)) u_index (
    .clk(clk), .rst_n(rst_n), .clear(st == S_COUNT), .step(line_pop),
    .total(nw_q), .idx(word_idx), .last(word_last)
  );

  always_comb begin
    unique case (op_q)
      OP_IDENT:   setup_cmd = C_IDENT;
      OP_ERASE:   setup_cmd = C_ERASE;
      OP_PROGRAM: setup_cmd = C_BUFWR;
      default:    setup_cmd = C_LOCKSET;
    endcase
  end

  always_comb begin
    bus_we    = 1'b0;
    bus_re    = 1'b0;
    bus_wdata = '0;
    bus_addr  = base_q;
    unique case (st)
      S_CLR:            begin bus_we = 1'b1; bus_wdata = lanes(C_CLEAR); end
      S_CHKQ, S_POLLQ:  begin bus_we = 1'b1; bus_wdata = lanes(C_STAT);  end
      S_CHKR, S_PRDBK,
      S_IDV, S_POLLR:   bus_re = 1'b1;
      S_IDD:            begin bus_re = 1'b1; bus_addr = base_q + AW'(STRIDE); end
      S_ID2:            begin bus_we = 1'b1; bus_wdata = lanes(C_IDENT);
                              bus_addr = base_q + AW'(STRIDE); end
      S_SETUP:          begin bus_we = 1'b1; bus_wdata = lanes(setup_cmd); end
      S_CONF:           begin bus_we = 1'b1;
                              bus_wdata = lanes(op_q == OP_LOCK ? C_LOCKCNF : C_CONFIRM); end
      S_COUNT:          begin bus_we = 1'b1; bus_wdata = count_word(8'(nw_q)); end
      S_DATA:           begin bus_we = 1'b1; bus_wdata = line_data;
                              bus_addr = base_q + (AW'(word_idx) << 2); end
      S_COMMIT:         begin bus_we = 1'b1; bus_wdata = lanes(C_CONFIRM); end
      S_ARRAY:          begin bus_we = 1'b1; bus_wdata = lanes(C_ARRAY); end
      default:          ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; op_q <= OP_STATUS; base_q <= '0; nw_q <= '0; lim_q <= '0;
      done <= 1'b0; res_status <= '0; res_timeout <= 1'b0; res_error <= 1'b0;
      id_vendor <= '0; id_device <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        base_q      <= req_addr;
        nw_q        <= req_len[LW-1:2];
        lim_q       <= poll_limit;
        res_status  <= '0;
        res_timeout <= 1'b0;
        res_error   <= 1'b0;
        unique case (req_op)
          3'd0:    begin op_q <= OP_IDENT;   st <= S_SETUP; end
          3'd1:    begin op_q <= OP_ERASE;   st <= S_CLR;   end
          3'd2:    begin op_q <= OP_LOCK;    st <= S_SETUP; end
          3'd3:    begin op_q <= OP_UNLOCK;  st <= S_SETUP; end
          3'd4:    begin op_q <= OP_PROGRAM; st <= S_SETUP; end
          default: begin op_q <= OP_STATUS;  st <= S_CLR;   end
        endcase
      end else if (xfer_done) begin
        unique case (st)
          S_CLR:   st <= S_CHKQ;
          S_CHKQ:  st <= S_CHKR;
          S_CHKR:
            if (!rd_ready) begin
              res_status <= bus_rdata; res_error <= any_error(bus_rdata); st <= S_ARRAY;
            end else if (op_q == OP_ERASE) st <= S_SETUP;
            else st <= S_ARRAY;
          S_SETUP:
            if (op_q == OP_IDENT)        st <= S_IDV;
            else if (op_q == OP_PROGRAM) st <= S_PRDBK;
            else                         st <= S_CONF;
          S_IDV:   begin id_vendor <= bus_rdata; st <= S_ID2; end
          S_ID2:   st <= S_IDD;
          S_IDD:   begin id_device <= bus_rdata; st <= S_ARRAY; end
          S_CONF:  st <= S_POLLQ;
          S_PRDBK:
            if (!rd_ready) begin
              res_status <= bus_rdata; res_error <= any_error(bus_rdata); st <= S_ARRAY;
            end else st <= S_COUNT;
          S_COUNT: st <= (nw_q == '0) ? S_COMMIT : S_DATA;
          S_DATA:  if (word_last) st <= S_COMMIT;
          S_COMMIT: st <= S_POLLQ;
          S_POLLQ: st <= S_POLLR;
          S_POLLR:
            if (rd_ready) begin
              res_status <= (bus_rdata == BOTH_READY) ? 32'h0 : bus_rdata;
              res_error  <= any_error(bus_rdata);
              st <= S_ARRAY;
            end else if (poll_expired) begin
              res_status <= '1; res_timeout <= 1'b1; res_error <= 1'b1; st <= S_ARRAY;
            end else st <= S_POLLQ;
          S_ARRAY: begin done <= 1'b1; st <= S_IDLE; end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_re)); // R1
  AST_HOLD_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_we || bus_re) && !bus_ack) |=> ($stable(bus_addr) && $stable(bus_wdata)
      && $stable(bus_we) && $stable(bus_re))); // R1
  AST_ENDS_IN_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(bus_we && bus_ack && bus_wdata == 32'hFFFF_FFFF)); // R7
  AST_TIMEOUT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_timeout) |-> (res_status == 32'hFFFF_FFFF && res_error)); // R9
  AST_ERROR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (done && any_error(res_status)) |-> res_error); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_we && !bus_re && !line_pop)); // R12
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10
  AST_POP_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    line_pop |-> (bus_we && bus_ack)); // R6
endmodule

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;
  localparam int AW = 24;
  localparam int LW = 8;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [2:0]    req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic [TW-1:0] poll_limit = '0;
  logic [31:0]   line_data;
  logic          line_pop, busy, done, res_timeout, res_error;
  logic [31:0]   res_status, id_vendor, id_device, bus_wdata;
  logic [AW-1:0] bus_addr;
  logic          bus_we, bus_re;
  logic [31:0]   bus_rdata = '0;
  logic          bus_ack = 1'b0;

  always #2.5 clk = ~clk;

  flash_cmd_seq #(.AW(AW), .LW(LW), .TW(TW)) i_flash_cmd_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_len(req_len), .poll_limit(poll_limit),
    .line_data(line_data), .line_pop(line_pop), .busy(busy), .done(done),
    .res_status(res_status), .res_timeout(res_timeout), .res_error(res_error),
    .id_vendor(id_vendor), .id_device(id_device), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  int n_done  = 0;

  // data source
  logic [31:0] dmem [16];
  int          didx = 0;
  logic        didx_clr = 1'b0;
  assign line_data = dmem[didx & 15];
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (done) n_done <= n_done + 1;
    if (didx_clr) didx <= 0;
    else if (line_pop) didx <= didx + 1;
  end

  // flash pair model and bus trace
  logic [7:0]  mode = 8'hFF;
  int          wait_left = 0;
  int          busy_left = 0;
  logic [31:0] fin_sta = 32'h0080_0080, chk_sta = 32'h0080_0080, prg_sta = 32'h0080_0080;
  bit          after_clr = 0, cnt_pending = 0;
  int          body_left = 0;
  int          n_log = 0;
  bit          log_we [128];
  logic [AW-1:0] log_a [128];
  logic [31:0] log_d [128];

  function automatic bit rdy(input logic [31:0] s);
    return s[7] && s[23];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      bus_ack <= 1'b0;
    end else if (bus_ack) begin
      bus_ack <= 1'b0;
    end else if (bus_we || bus_re) begin
      if (wait_left > 0) wait_left = wait_left - 1;
      else begin
        wait_left = $urandom % 3;
        bus_ack <= 1'b1;
        if (n_log < 128) begin
          log_we[n_log] = bus_we; log_a[n_log] = bus_addr;
          log_d[n_log] = bus_we ? bus_wdata : 32'h0;
        end
        n_log = n_log + 1;
        if (bus_we) begin
          if (cnt_pending) begin body_left = int'(bus_wdata[7:0]) + 1; cnt_pending = 0; end
          else if (body_left > 0) body_left = body_left - 1;
          else begin mode = bus_wdata[7:0]; if (mode == 8'h50) after_clr = 1; end
        end else begin
          case (mode)
            8'h90: bus_rdata <= 32'h5A00_0000 | 32'(bus_addr);
            8'h70: begin
              if (after_clr) begin after_clr = 0; bus_rdata <= chk_sta; end
              else if (busy_left > 0) begin
                busy_left = busy_left - 1;
                bus_rdata <= (busy_left % 2 == 0) ? 32'h0000_0080 : 32'h0080_0000;
              end else bus_rdata <= fin_sta;
            end
            8'hE8: begin bus_rdata <= prg_sta; if (rdy(prg_sta)) cnt_pending = 1; end
            default: bus_rdata <= 32'hDEAD_BEEF;
          endcase
        end
      end
    end
  end

  // expected trace
  int          n_exp = 0;
  bit          exp_we [128];
  logic [AW-1:0] exp_a [128];
  logic [31:0] exp_d [128];

  function automatic logic [31:0] rep(input logic [7:0] b);
    return {b, b, b, b};
  endfunction

  function automatic bit errbits(input logic [31:0] s);
    return s[5] | s[4] | s[3] | s[1] | s[21] | s[20] | s[19] | s[17];
  endfunction

  task automatic ew(input logic [AW-1:0] a, input logic [31:0] d);
    exp_we[n_exp] = 1; exp_a[n_exp] = a; exp_d[n_exp] = d; n_exp++;
  endtask
  task automatic er(input logic [AW-1:0] a);
    exp_we[n_exp] = 0; exp_a[n_exp] = a; exp_d[n_exp] = 0; n_exp++;
  endtask
  task automatic epoll(input logic [AW-1:0] b, input int polls);
    for (int i = 0; i <= polls; i++) begin ew(b, rep(8'h70)); er(b); end
  endtask

  task automatic build(input int op, input logic [AW-1:0] b, input int nw,
                       input int polls);
    n_exp = 0;
    case (op)
      0: begin ew(b, rep(8'h90)); er(b); ew(b + 4, rep(8'h90)); er(b + 4); end
      1: begin ew(b, rep(8'h50)); ew(b, rep(8'h70)); er(b);
               if (rdy(chk_sta)) begin ew(b, rep(8'h20)); ew(b, rep(8'hD0)); epoll(b, polls); end end
      2: begin ew(b, rep(8'h60)); ew(b, rep(8'h01)); epoll(b, polls); end
      3: begin ew(b, rep(8'h60)); ew(b, rep(8'hD0)); epoll(b, polls); end
      4: begin ew(b, rep(8'hE8)); er(b);
               if (rdy(prg_sta)) begin
                 ew(b, rep(8'(nw - 1)));
                 for (int i = 0; i < nw; i++) ew(b + AW'(4 * i), dmem[i]);
                 ew(b, rep(8'hD0)); epoll(b, polls);
               end end
      default: begin ew(b, rep(8'h50)); ew(b, rep(8'h70)); er(b); end
    endcase
    ew(b, rep(8'hFF));
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_trace(input string req);
    int bad = -1;
    if (n_log != n_exp) bad = (n_log < n_exp) ? n_log : n_exp;
    else for (int i = 0; i < n_exp && bad < 0; i++)
      if (log_we[i] != exp_we[i] || log_a[i] != exp_a[i] || log_d[i] != exp_d[i]) bad = i;
    n_tests++;
    if (bad >= 0) begin
      n_fail++;
      $display("FAIL %s trace at %0d (len %0d/%0d): actual we%0d %h %h expected we%0d %h %h",
               req, bad, n_log, n_exp, log_we[bad & 127], log_a[bad & 127], log_d[bad & 127],
               exp_we[bad & 127], exp_a[bad & 127], exp_d[bad & 127]);
    end
  endtask

  // issue one request; optional stray request while busy
  task automatic run_op(input int op, input logic [AW-1:0] b, input int len,
                        input int lim, input bit stray);
    int g = 0;
    int d0;
    @(negedge clk);
    n_log = 0; didx_clr = 1'b1; d0 = n_done;
    req_valid = 1'b1; req_op = 3'(op); req_addr = b; req_len = LW'(len);
    poll_limit = TW'(lim);
    @(negedge clk);
    req_valid = 1'b0; didx_clr = 1'b0;
    check("R10 busy after accept", 32'(busy), 32'd1);
    if (stray) begin
      repeat (2) @(negedge clk);
      req_valid = 1'b1; req_op = 3'd4; req_addr = b + 24'h100;
      repeat (2) @(negedge clk);
      req_valid = 1'b0;
    end
    while (!done && g < 20000) begin @(negedge clk); g++; end
    if (!done) check("R10 done timeout", 32'd0, 32'd1);
    check("R10 single done", 32'(n_done - d0 + (done ? 1 : 0)), 32'd1);
  endtask

  function automatic logic [31:0] final_res(input logic [31:0] s);
    return (s == 32'h0080_0080) ? 32'h0 : s;
  endfunction

  initial begin
    logic [AW-1:0] base;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) dmem[i] = $urandom;

    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 busy", 32'(busy), 0);
    check("R12 strobes", 32'({bus_we, bus_re, line_pop, done}), 0);
    rst_n = 1'b1;

    // R1 identify
    base = 24'h01_2340;
    build(0, base, 0, 0); run_op(0, base, 0, 100, 0);
    check_trace("R1 identify");
    check("R1 vendor", id_vendor, 32'h5A00_0000 | 32'(base));
    check("R1 device", id_device, 32'h5A00_0000 | 32'(base + 4));
    check("R1 status", res_status, 0);

    // R11 status check, ready and half-ready (R2)
    chk_sta = 32'h0080_0080; build(5, base, 0, 0); run_op(5, base, 0, 100, 0);
    check_trace("R11 check"); check("R11 ready result", res_status, 0);
    chk_sta = 32'h0000_0080; build(5, base, 0, 0); run_op(5, base, 0, 100, 0);
    check("R2 half ready not ready", res_status, 32'h0000_0080);
    check("R11 no error bits", 32'(res_error), 0);

    // R3 erase with polls, and aborted erase
    chk_sta = 32'h0080_0080; busy_left = 3; fin_sta = 32'h0080_0080;
    build(1, 24'h02_0000, 0, 3); run_op(1, 24'h02_0000, 0, 1000, 0);
    check_trace("R3 erase R2 polls"); check("R3 erase result", res_status, 0);
    chk_sta = 32'h0020_0080; build(1, 24'h04_0000, 0, 0); run_op(1, 24'h04_0000, 0, 1000, 0);
    check_trace("R3 erase abort R7");
    check("R3 abort status", res_status, 32'h0020_0080);
    check("R8 abort error", 32'(res_error), 1);

    // R4 lock with error status, unlock with stray request (R10)
    chk_sta = 32'h0080_0080; busy_left = 1; fin_sta = 32'h0082_0080;
    build(2, 24'h06_0000, 0, 1); run_op(2, 24'h06_0000, 0, 1000, 0);
    check_trace("R4 lock"); check("R8 lock raw status", res_status, 32'h0082_0080);
    check("R8 lock error", 32'(res_error), 1);
    busy_left = 2; fin_sta = 32'h0080_0080;
    build(3, 24'h06_0000, 0, 2); run_op(3, 24'h06_0000, 0, 1000, 1);
    check_trace("R4 unlock R10 stray ignored");
    repeat (6) @(negedge clk);
    check("R10 stray did not start", 32'(busy), 0);

    // R8 non-error extra bit
    busy_left = 0; fin_sta = 32'h00C0_0080;
    build(3, base, 0, 0); run_op(3, base, 0, 1000, 0);
    check("R8 extra bit raw", res_status, 32'h00C0_0080);
    check("R8 extra bit no error", 32'(res_error), 0);

    // R5 program readback not ready
    prg_sta = 32'h0080_0000; build(4, base, 4, 0); run_op(4, base, 16, 1000, 0);
    check_trace("R5 program abort R7"); check("R5 abort status", res_status, 32'h0080_0000);

    // R6 program at max lines, and 1 word
    prg_sta = 32'h0080_0080; busy_left = 2; fin_sta = 32'h0080_0080;
    build(4, 24'h10_0000, 16, 2); run_op(4, 24'h10_0000, 64, 1000, 0);
    check_trace("R6 program 16 words"); check("R6 result", res_status, 0);
    busy_left = 0; build(4, 24'h10_0040, 1, 0); run_op(4, 24'h10_0040, 4, 1000, 0);
    check_trace("R6 program 1 word");

    // R9 timeout
    busy_left = 100000; run_op(2, base, 0, 30, 0);
    check("R9 timeout status", res_status, 32'hFFFF_FFFF);
    check("R9 timeout flag", 32'(res_timeout), 1);
    check("R9 timeout error", 32'(res_error), 1);
    check("R7 timeout ends in array", log_d[(n_log - 1) & 127], 32'hFFFF_FFFF);
    busy_left = 0;

    // random mix
    for (int k = 0; k < 24; k++) begin
      int op, nw, polls;
      logic [31:0] exp_res;
      bit exp_err;
      op = $urandom % 6; nw = 1 + $urandom % 16; polls = $urandom % 4;
      base = AW'(($urandom % 24'h3F_FFFF) << 2);
      chk_sta = ($urandom % 3 == 0) ? 32'h0080_0000 : 32'h0080_0080;
      prg_sta = ($urandom % 4 == 0) ? 32'h0000_0080 : 32'h0080_0080;
      case ($urandom % 4)
        0: fin_sta = 32'h0080_0080;
        1: fin_sta = 32'h00C0_0080;
        2: fin_sta = 32'h0080_0090;
        default: fin_sta = 32'h0088_0080;
      endcase
      for (int i = 0; i < 16; i++) dmem[i] = $urandom;
      busy_left = polls;
      build(op, base, nw, polls);
      run_op(op, base, nw * 4, 5000, 0);
      check_trace("R1 R3 R4 R6 R7 random trace");
      exp_res = 0; exp_err = 0;
      if (op == 5 || op == 1) begin
        if (!rdy(chk_sta)) begin exp_res = chk_sta; exp_err = errbits(chk_sta); end
        else if (op == 1) begin exp_res = final_res(fin_sta); exp_err = errbits(fin_sta); end
      end else if (op == 4 && !rdy(prg_sta)) begin
        exp_res = prg_sta; exp_err = errbits(prg_sta);
      end else if (op != 0) begin
        exp_res = final_res(fin_sta); exp_err = errbits(fin_sta);
      end
      check("R8 random result", res_status, exp_res);
      check("R8 random error", 32'(res_error), 32'(exp_err));
      busy_left = 0;
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule